// File: doc/BRIEF.md
# Hierarchical Idle State Coordinator

This block settles how deep a multi-core package may sleep. Every hardware thread of every core presents an idle request, coded as a 3-bit level. The block reduces these requests to one level per core, and then to one level for the whole package. When the enhanced-C1 option is on, it tags the C1 results with a flag. Before the package may report its deepest level, the block runs a cache-emptying handshake with the last-level cache. A per-core wake input pulls that core, and with it the package, back to the running state. An optional demotion filter limits deep-state entries. It counts deep entries inside a fixed cycle window, and once the count passes a threshold it treats C6 and C7 requests as C3 until the window ends.

The block is placed between the threads' idle hints and the package power sequencer. The sequencer reads the registered core and package levels. The cache controller sees a single request line, which stays high until it answers with a done pulse or level.

Top module: `idle_coord`

## Requirements
- R1: Level codes are C0=0, C1=1, C3=3, C6=6 and C7=7. Each core's output level is the smallest code requested by its threads, taken after demotion, and it appears one clock after the requests are sampled.
- R2: The package level is the smallest of the core levels produced in the same cycle. The only exception is the deepest level, which is governed by R5.
- R3: When `c1eEn` is high and every core resolves to C1 or deeper, each core at C1 raises its `coreC1e` bit, and a package at C1 raises `pkgC1e`. In every other case these flags are low.
- R4: Once every core resolves to C7, the next cycle raises `flushReq` and the package reports C6 instead of C7.
- R5: The package reports C7 only in the cycle after `flushDone` was sampled high while `flushReq` was high and all cores still resolved to C7. In that same cycle `flushReq` falls.
- R6: `flushReq` stays high for as long as all cores remain at C7 and `flushDone` is low.
- R7: If any core leaves C7 while `flushReq` is high, `flushReq` falls in the next cycle and the package follows the new minimum.
- R8: A high `wake[c]` makes core c report C0 in the next cycle, whatever its threads request. The package then also reports C0, and any pending flush is abandoned.
- R9: A deep entry is a core whose level goes from below C6 to C6 or C7. Entries are counted over the window. With `demoteEn` high, once the running count exceeds DEMOTE_THRESH, all C6 and C7 thread requests are treated as C3 from the following cycle on.
- R10: The window is WINDOW_LEN cycles long and starts at reset. At its last cycle the entry count and the demotion state are cleared, and entries in that cycle are dropped.
- R11: While reset is held, every core level and the package level are C0, and all flags and `flushReq` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| threadReq | input | NUM_CORES*THREADS*3 | Thread idle requests; thread t of core c at bits (c*THREADS+t)*3 +: 3 |
| wake | input | NUM_CORES | Per-core wake event |
| c1eEn | input | 1 | Enable the enhanced C1 flag |
| demoteEn | input | 1 | Enable deep-state demotion |
| flushDone | input | 1 | Cache reports it is empty |
| coreLevel | output | NUM_CORES*3 | Resolved level per core; core c at bits c*3 +: 3 |
| coreC1e | output | NUM_CORES | Enhanced C1 flag per core |
| pkgLevel | output | 3 | Resolved package level |
| pkgC1e | output | 1 | Enhanced C1 flag for the package |
| flushReq | output | 1 | Cache shrink request |

## Verification
The assertions take the thread requests to be legal codes (0, 1, 3, 6 or 7). They also assume `flushDone` is only raised while `flushReq` is high. The bench draws every request from the five legal codes. Its cache model raises `flushDone` only after counting a fixed number of ways times a per-way latency with `flushReq` held, and drops it at once when the request falls. Wake pulses and demotion bursts are driven at the negedge, so every request is stable before the sampling edge.

// File: rtl/idle_coord_pkg.sv
package idle_coord_pkg;
  localparam int LVL_W = 3;
  typedef logic [LVL_W-1:0] lvl_t;

  localparam lvl_t LVL_C0 = 3'd0;
  localparam lvl_t LVL_C1 = 3'd1;
  localparam lvl_t LVL_C3 = 3'd3;
  localparam lvl_t LVL_C6 = 3'd6;
  localparam lvl_t LVL_C7 = 3'd7;

  typedef enum logic [1:0] {
    PKG_ACTIVE = 2'd0,
    PKG_FLUSH  = 2'd1,
    PKG_DEEP   = 2'd2
  } pkg_state_e;

  // strobes from package control to the resolve datapath
  typedef struct packed {
    logic deepNext;
    logic flushNext;
  } pkg_strobe_t;
endpackage

// File: rtl/idle_resolve_dp.sv
module idle_resolve_dp
  import idle_coord_pkg::*;
#(
  parameter int NUM_CORES     = 2,
  parameter int THREADS       = 2,
  parameter int WINDOW_LEN    = 64,
  parameter int DEMOTE_THRESH = 3
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  logic [NUM_CORES*THREADS*LVL_W-1:0]   threadReq,
  input  logic [NUM_CORES-1:0]                 wake,
  input  logic                                 c1eEn,
  input  logic                                 demoteEn,
  input  pkg_strobe_t                          strobe,
  output lvl_t                                 pkgMin,
  output logic [NUM_CORES*LVL_W-1:0]           coreLevel,
  output logic [NUM_CORES-1:0]                 coreC1e,
  output lvl_t                                 pkgLevel,
  output logic                                 pkgC1e
);
  localparam int WIN_W = (WINDOW_LEN > 2) ? $clog2(WINDOW_LEN) : 1;
  localparam int CNT_W = $clog2(DEMOTE_THRESH + NUM_CORES + 2) + 1;
  localparam int ENT_W = $clog2(NUM_CORES + 1);
  localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WINDOW_LEN - 1);
  localparam logic [CNT_W-1:0] THRESH   = CNT_W'(DEMOTE_THRESH);

  lvl_t coreQ [NUM_CORES];
  lvl_t coreD [NUM_CORES];

  logic             demoteQ;
  logic [WIN_W-1:0] winQ;
  logic [CNT_W-1:0] entQ;
  logic             demoteOn;

  assign demoteOn = demoteQ & demoteEn;

  // per-core minimum over threads, with demotion and wake override
  for (genvar gc = 0; gc < NUM_CORES; gc++) begin : g_core
    always_comb begin
      lvl_t m;
      lvl_t r;
      m = LVL_C7;
      for (int t = 0; t < THREADS; t++) begin
        r = threadReq[(gc*THREADS+t)*LVL_W +: LVL_W];
        if (demoteOn && r >= LVL_C6) r = LVL_C3;
        if (r < m) m = r;
      end
      if (wake[gc]) m = LVL_C0;
      coreD[gc] = m;
    end
    assign coreLevel[gc*LVL_W +: LVL_W] = coreQ[gc];
  end

  logic             allGe1;
  logic [ENT_W-1:0] entries;

  always_comb begin
    pkgMin  = LVL_C7;
    allGe1  = 1'b1;
    entries = '0;
    for (int c = 0; c < NUM_CORES; c++) begin
      if (coreD[c] < pkgMin) pkgMin = coreD[c];
      if (coreD[c] == LVL_C0) allGe1 = 1'b0;
      if (coreQ[c] < LVL_C6 && coreD[c] >= LVL_C6) entries = entries + ENT_W'(1);
    end
  end

  logic [CNT_W-1:0] entSum;
  assign entSum = entQ + CNT_W'(entries);

  // demotion window: count deep entries, saturate just above the threshold
  always_ff @(posedge clk) begin
    if (!rstN) begin
      winQ    <= '0;
      entQ    <= '0;
      demoteQ <= 1'b0;
    end else if (winQ == WIN_LAST) begin
      winQ    <= '0;
      entQ    <= '0;
      demoteQ <= 1'b0;
    end else begin
      winQ    <= winQ + WIN_W'(1);
      entQ    <= (entSum > THRESH) ? THRESH + CNT_W'(1) : entSum;
      if (demoteEn && entSum > THRESH) demoteQ <= 1'b1;
    end
  end

  // registered results
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int c = 0; c < NUM_CORES; c++) coreQ[c] <= LVL_C0;
      coreC1e  <= '0;
      pkgLevel <= LVL_C0;
      pkgC1e   <= 1'b0;
    end else begin
      for (int c = 0; c < NUM_CORES; c++) begin
        coreQ[c]   <= coreD[c];
        coreC1e[c] <= c1eEn && allGe1 && (coreD[c] == LVL_C1);
      end
      pkgLevel <= strobe.deepNext  ? LVL_C7 :
                  strobe.flushNext ? LVL_C6 : pkgMin;
      pkgC1e   <= c1eEn && (pkgMin == LVL_C1);
    end
  end
endmodule

// File: rtl/idle_pkg_ctrl.sv
module idle_pkg_ctrl
  import idle_coord_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  lvl_t        pkgMin,
  input  logic        flushDone,
  output pkg_strobe_t strobe,
  output logic        flushReq
);
  pkg_state_e stateQ, stateD;

  always_comb begin
    stateD = stateQ;
    case (stateQ)
      PKG_ACTIVE: if (pkgMin == LVL_C7) stateD = PKG_FLUSH;
      PKG_FLUSH: begin
        if (pkgMin != LVL_C7)  stateD = PKG_ACTIVE;
        else if (flushDone)    stateD = PKG_DEEP;
      end
      PKG_DEEP:   if (pkgMin != LVL_C7) stateD = PKG_ACTIVE;
      default:    stateD = PKG_ACTIVE;
    endcase
  end

  assign strobe.deepNext  = (stateD == PKG_DEEP);
  assign strobe.flushNext = (stateD == PKG_FLUSH);
  assign flushReq         = (stateQ == PKG_FLUSH);

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= PKG_ACTIVE;
    else       stateQ <= stateD;
  end
endmodule

// File: rtl/idle_coord.sv
module idle_coord
  import idle_coord_pkg::*;
#(
  parameter int NUM_CORES     = 2,
  parameter int THREADS       = 2,
  parameter int WINDOW_LEN    = 64,
  parameter int DEMOTE_THRESH = 3
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic [NUM_CORES*THREADS*3-1:0]     threadReq,
  input  logic [NUM_CORES-1:0]               wake,
  input  logic                               c1eEn,
  input  logic                               demoteEn,
  input  logic                               flushDone,
  output logic [NUM_CORES*3-1:0]             coreLevel,
  output logic [NUM_CORES-1:0]               coreC1e,
  output logic [2:0]                         pkgLevel,
  output logic                               pkgC1e,
  output logic                               flushReq
);
  pkg_strobe_t strobe;
  lvl_t        pkgMin;

  idle_resolve_dp #(
    .NUM_CORES(NUM_CORES), .THREADS(THREADS),
    .WINDOW_LEN(WINDOW_LEN), .DEMOTE_THRESH(DEMOTE_THRESH)
  ) u_dp (
    .clk(clk), .rstN(rstN), .threadReq(threadReq), .wake(wake),
    .c1eEn(c1eEn), .demoteEn(demoteEn), .strobe(strobe), .pkgMin(pkgMin),
    .coreLevel(coreLevel), .coreC1e(coreC1e), .pkgLevel(pkgLevel), .pkgC1e(pkgC1e)
  );

  idle_pkg_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .pkgMin(pkgMin), .flushDone(flushDone),
    .strobe(strobe), .flushReq(flushReq)
  );
endmodule

// File: rtl/idle_coord_chk.sv
module idle_coord_chk #(
  parameter int NUM_CORES = 2
) (
  input logic                   clk,
  input logic                   rstN,
  input logic [NUM_CORES-1:0]   wake,
  input logic                   flushDone,
  input logic [NUM_CORES*3-1:0] coreLevel,
  input logic [NUM_CORES-1:0]   coreC1e,
  input logic [2:0]             pkgLevel,
  input logic                   pkgC1e,
  input logic                   flushReq
);
  assert_flush_shows_c6_R4: assert property (@(posedge clk) disable iff (!rstN)
    flushReq |-> pkgLevel == 3'd6);

  assert_deep_after_done_R5: assert property (@(posedge clk) disable iff (!rstN)
    (pkgLevel == 3'd7 && $past(pkgLevel) != 3'd7) |-> $past(flushReq && flushDone));

  assert_fall_with_deep_R6: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(flushReq) && pkgLevel == 3'd7) |-> $past(flushDone));

  assert_pkg_flag_R3: assert property (@(posedge clk) disable iff (!rstN)
    pkgC1e |-> pkgLevel == 3'd1);

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_chk
    assert_wake_R8: assert property (@(posedge clk) disable iff (!rstN)
      wake[c] |=> (coreLevel[c*3 +: 3] == 3'd0 && pkgLevel == 3'd0 && !flushReq));

    assert_pkg_min_R2: assert property (@(posedge clk) disable iff (!rstN)
      pkgLevel <= coreLevel[c*3 +: 3]);

    assert_core_flag_R3: assert property (@(posedge clk) disable iff (!rstN)
      coreC1e[c] |-> coreLevel[c*3 +: 3] == 3'd1);
  end
endmodule

bind idle_coord idle_coord_chk #(.NUM_CORES(NUM_CORES)) u_chk (
  .clk(clk), .rstN(rstN), .wake(wake), .flushDone(flushDone),
  .coreLevel(coreLevel), .coreC1e(coreC1e), .pkgLevel(pkgLevel),
  .pkgC1e(pkgC1e), .flushReq(flushReq)
);

// File: tb/idle_coord_tb.sv
module idle_coord_tb;
  localparam int NC = 2;
  localparam int NT = 2;
  localparam int WIN = 32;
  localparam int THR = 2;
  localparam int WAYS = 4;
  localparam int STEP = 3;

  logic              clk = 1'b0;
  logic              rstN;
  logic [NC*NT*3-1:0] threadReq;
  logic [NC-1:0]     wake;
  logic              c1eEn, demoteEn, flushDone;
  logic [NC*3-1:0]   coreLevel;
  logic [NC-1:0]     coreC1e;
  logic [2:0]        pkgLevel;
  logic              pkgC1e, flushReq;

  always #4 clk = ~clk;

  idle_coord #(.NUM_CORES(NC), .THREADS(NT), .WINDOW_LEN(WIN), .DEMOTE_THRESH(THR)) u_dut (
    .clk(clk), .rstN(rstN), .threadReq(threadReq), .wake(wake), .c1eEn(c1eEn),
    .demoteEn(demoteEn), .flushDone(flushDone), .coreLevel(coreLevel),
    .coreC1e(coreC1e), .pkgLevel(pkgLevel), .pkgC1e(pkgC1e), .flushReq(flushReq));

  int vectors = 0;
  int fails = 0;
  string phase = "R11 reset";
  int shrinkCnt = 0;

  // behavioural reference: 0 active, 1 flushing, 2 deep
  int mCore [NC];
  int mC1e  [NC];
  int mPkg, mPkgC1e, mState, mWin, mEnt, mDemote;

  always @(posedge clk) begin
    int n [NC];
    int pm, ent, r, lvl, allGe1, dem;
    if (!rstN) begin
      for (int c = 0; c < NC; c++) begin mCore[c] = 0; mC1e[c] = 0; end
      mPkg = 0; mPkgC1e = 0; mState = 0; mWin = 0; mEnt = 0; mDemote = 0;
    end else begin
      dem = mDemote & demoteEn;
      pm = 7; ent = 0; allGe1 = 1;
      for (int c = 0; c < NC; c++) begin
        lvl = 7;
        for (int t = 0; t < NT; t++) begin
          r = int'(threadReq[(c*NT+t)*3 +: 3]);
          if (dem != 0 && r >= 6) r = 3;
          if (r < lvl) lvl = r;
        end
        if (wake[c]) lvl = 0;
        n[c] = lvl;
        if (lvl < pm) pm = lvl;
        if (lvl == 0) allGe1 = 0;
        if (mCore[c] < 6 && lvl >= 6) ent++;
      end
      if (mWin == WIN-1) begin
        mWin = 0; mEnt = 0; mDemote = 0;
      end else begin
        mWin++;
        mEnt += ent;
        if (demoteEn && mEnt > THR) mDemote = 1;
      end
      case (mState)
        0: if (pm == 7) mState = 1;
        1: if (pm != 7) mState = 0; else if (flushDone) mState = 2;
        default: if (pm != 7) mState = 0;
      endcase
      for (int c = 0; c < NC; c++) begin
        mC1e[c]  = (c1eEn && allGe1 != 0 && n[c] == 1) ? 1 : 0;
        mCore[c] = n[c];
      end
      mPkg    = (mState == 2) ? 7 : (mState == 1) ? 6 : pm;
      mPkgC1e = (c1eEn && pm == 1) ? 1 : 0;
    end
  end

  task automatic expect_eq(string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", phase, what, act, exp);
    end
  endtask

  task automatic compare_all();
    for (int c = 0; c < NC; c++) begin
      expect_eq($sformatf("R1 core%0d level", c), int'(coreLevel[c*3 +: 3]), mCore[c]);
      expect_eq($sformatf("R3 core%0d c1e", c), int'(coreC1e[c]), mC1e[c]);
    end
    expect_eq("R2 package level", int'(pkgLevel), mPkg);
    expect_eq("R3 package c1e", int'(pkgC1e), mPkgC1e);
    expect_eq("R4 flushReq", int'(flushReq), (mState == 1) ? 1 : 0);
  endtask

  // one cycle: inputs already set; compare at the next negedge, then update the cache model
  task automatic step();
    @(posedge clk);
    @(negedge clk);
    compare_all();
    if (flushReq) begin
      shrinkCnt++;
      flushDone = (shrinkCnt >= WAYS*STEP);
    end else begin
      shrinkCnt = 0;
      flushDone = 1'b0;
    end
  endtask

  function automatic logic [2:0] pick(int k);
    case (k % 5)
      0: return 3'd0;
      1: return 3'd1;
      2: return 3'd3;
      3: return 3'd6;
      default: return 3'd7;
    endcase
  endfunction

  task automatic set_all(logic [2:0] v);
    for (int i = 0; i < NC*NT; i++) threadReq[i*3 +: 3] = v;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    bit seen;
    rstN = 1'b0; threadReq = '0; wake = '0; c1eEn = 1'b0; demoteEn = 1'b0; flushDone = 1'b0;
    set_all(3'd7);
    repeat (3) @(negedge clk);
    // R11: reset holds everything at C0 even with deep requests
    expect_eq("R11 pkgLevel", int'(pkgLevel), 0);
    expect_eq("R11 flushReq", int'(flushReq), 0);
    expect_eq("R11 coreLevel", int'(coreLevel), 0);
    compare_all();
    rstN = 1'b1;
    set_all(3'd0);

    phase = "R1 random";
    for (int i = 0; i < 60; i++) begin
      for (int k = 0; k < NC*NT; k++) threadReq[k*3 +: 3] = pick(int'($urandom_range(0, 4)));
      step();
    end

    phase = "R3 c1e random";
    c1eEn = 1'b1;
    for (int i = 0; i < 60; i++) begin
      for (int k = 0; k < NC*NT; k++) threadReq[k*3 +: 3] = pick(int'($urandom_range(1, 4)));
      step();
    end
    set_all(3'd1);
    step(); step();
    expect_eq("R3 explicit pkgC1e", int'(pkgC1e), 1);
    c1eEn = 1'b0;
    step();
    expect_eq("R3 disabled pkgC1e", int'(pkgC1e), 0);

    phase = "R5 flush";
    set_all(3'd7);
    step();
    expect_eq("R4 flushReq raised", int'(flushReq), 1);
    expect_eq("R4 pkg shows C6", int'(pkgLevel), 6);
    for (int i = 0; i < WAYS*STEP - 2; i++) step();
    expect_eq("R6 flushReq held", int'(flushReq), 1);
    for (int i = 0; i < 4; i++) step();
    expect_eq("R5 pkg at C7", int'(pkgLevel), 7);
    expect_eq("R5 flushReq dropped", int'(flushReq), 0);

    phase = "R8 wake";
    wake = 2'b10;
    step();
    expect_eq("R8 core1 C0", int'(coreLevel[3 +: 3]), 0);
    expect_eq("R8 pkg C0", int'(pkgLevel), 0);
    wake = '0;
    for (int i = 0; i < 4; i++) step();
    wake = 2'b01;
    step();
    expect_eq("R8 abort flushReq", int'(flushReq), 0);
    expect_eq("R8 abort pkg", int'(pkgLevel), 0);
    wake = '0;
    step();

    phase = "R7 abort";
    set_all(3'd0);
    step();
    set_all(3'd7);
    for (int i = 0; i < 4; i++) step();
    threadReq[2*3 +: 3] = 3'd3;
    step();
    expect_eq("R7 flushReq fell", int'(flushReq), 0);
    expect_eq("R7 pkg follows min", int'(pkgLevel), 3);

    phase = "R9 demote";
    demoteEn = 1'b1;
    set_all(3'd7);
    seen = 0;
    for (int i = 0; i < 20; i++) begin
      threadReq[0 +: 3] = (i % 2 == 0) ? 3'd0 : 3'd7;
      step();
      if (coreLevel[3 +: 3] == 3'd3) seen = 1;
    end
    expect_eq("R9 demoted to C3 seen", int'(seen), 1);

    phase = "R10 window clear";
    set_all(3'd7);
    for (int i = 0; i < WIN + 4; i++) step();
    expect_eq("R10 core0 back to C7", int'(coreLevel[0 +: 3]), 7);
    demoteEn = 1'b0;

    phase = "R1 mixed wake";
    for (int i = 0; i < 80; i++) begin
      for (int k = 0; k < NC*NT; k++) threadReq[k*3 +: 3] = pick(int'($urandom_range(2, 4)) + ((i % 7 == 0) ? 1 : 0));
      wake = (i % 11 == 0) ? NC'($urandom_range(0, 3)) : '0;
      c1eEn = i[3];
      step();
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule